// File: doc/BRIEF.md
# Multi-Level Priority Interrupt Controller

This block arbitrates interrupts for a 16-bit real-time processor across 24 levels whose priority is fixed by hardware. Level 0 is the most urgent and level 23 the least. Each level gathers 16 condition lines. A rising edge on a line latches one bit in that level's status word. The bit stays set until software reads the word, and the read clears exactly the bits it returned. A level is pending while its status word is nonzero. Software finds the condition that fired by polling that word. Conditions have no vectors of their own.

A pending level may interrupt only if it is unmasked and neither it nor any more urgent level is in service. The most urgent such level is offered to the processor as a forced-branch request. The request carries a 16-bit target address, which is a constant base plus the level number. When the processor acknowledges, that level becomes in service. An end-of-service strobe retires the most urgent level currently in service, and this lets less urgent levels through again.

The sequencer has two states. ST_IDLE takes transition T_RAISE to ST_REQ when some level is eligible, and it latches that level. ST_REQ takes T_ACCEPT back to ST_IDLE on acknowledge and marks the level in service. It takes T_WITHDRAW back to ST_IDLE when the offered level is no longer eligible, or when a different level has become the best candidate. Otherwise it holds in ST_REQ.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `irq_o` is 0, `lvl_o` is 0, `rd_data_o` is 0, every level is unmasked, no level is in service, and every status word reads as 0.
- R2: A 0-to-1 transition on `cond_i[l*16+b]` sets bit b of level l's status word. A line held high does not set the bit again after a read has cleared it. A falling edge has no effect.
- R3: With `rd_en_i` high, `rd_data_o` shows the status word of level `rd_lvl_i` on the next cycle, and the bits returned are cleared. A rising edge in the same cycle as the read survives the read. A level number of 24 or more returns 0.
- R4: A level is pending while its status word is nonzero. One cycle after the sequencer sees an eligible level, `irq_o` is 1, `lvl_o` is that level, and `vec_o` is `VEC_BASE + lvl_o` (default base 0x0008).
- R5: When several levels are eligible, the lowest-numbered one is offered.
- R6: A mask write sets the mask to `mask_wdata_i`, where bit l = 1 masks level l. The new mask takes effect from the next cycle. A masked level keeps its pending status and is offered once it is unmasked.
- R7: Level l is not offered while level l or any level below l in number is in service.
- R8: `ack_i` while `irq_o` is 1 puts level `lvl_o` in service, and `irq_o` is 0 on the next cycle.
- R9: `eos_i` removes the lowest-numbered in-service level. With no level in service it has no effect.
- R10: If `ack_i` and `eos_i` arrive in the same cycle, both take effect. The end-of-service acts on the levels that were in service before the acknowledge.
- R11: If the offered level stops being eligible, or a different level becomes the best candidate, before acknowledge, `irq_o` drops on the next cycle. The new best level is offered on the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cond_i | input | 384 | Condition lines; line b of level l is bit l*16+b |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 24 | New mask value, 1 = level masked |
| ack_i | input | 1 | Processor acknowledge of the current request |
| eos_i | input | 1 | End-of-service strobe |
| rd_en_i | input | 1 | Status read-and-clear strobe |
| rd_lvl_i | input | 5 | Level whose status word is read |
| irq_o | output | 1 | Forced-branch request |
| lvl_o | output | 5 | Level being offered |
| vec_o | output | 16 | Branch target address for the offered level |
| rd_data_o | output | 16 | Status word returned by the last read |

## Verification
Several functions can land on the same clock edge. An acknowledge can meet an end-of-service strobe, and a status read can meet a new rising edge on a bit of the word being read. The bench provokes both pairs on purpose and also lets random traffic collide. Each collision is judged against a behavioural reference model that applies both effects from pre-edge state. Its verdict is confirmed by what is offered next: which level `irq_o` presents once service is retired, and what a second read of the same word returns.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } pic_state_e;
endpackage

// File: rtl/pic_level_status.sv
module pic_level_status #(
    parameter int NCOND = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCOND-1:0] cond,
    input  logic             rd_hit,
    output logic [NCOND-1:0] status,
    output logic             pending
);
    logic [NCOND-1:0] cond_q;
    logic [NCOND-1:0] rise;
    logic [NCOND-1:0] clr;

    assign rise    = cond & ~cond_q;
    assign clr     = rd_hit ? status : '0;
    assign pending = |status;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= '0;
            status <= '0;
        end else begin
            cond_q <= cond;
            status <= (status & ~clr) | rise;
        end
    end
endmodule

// File: rtl/pic_first_set.sv
module pic_first_set #(
    parameter int N  = 24,
    parameter int IW = 5
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int            NLEV     = 24,
    parameter int            NCOND    = 16,
    parameter int            AW       = 16,
    parameter int            LW       = $clog2(NLEV),
    parameter logic [AW-1:0] VEC_BASE = 16'h0008
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NLEV*NCOND-1:0] cond_i,
    input  logic                  mask_we_i,
    input  logic [NLEV-1:0]       mask_wdata_i,
    input  logic                  ack_i,
    input  logic                  eos_i,
    input  logic                  rd_en_i,
    input  logic [LW-1:0]         rd_lvl_i,
    output logic                  irq_o,
    output logic [LW-1:0]         lvl_o,
    output logic [AW-1:0]         vec_o,
    output logic [NCOND-1:0]      rd_data_o
);
    pic_state_e state_q, state_nx;
    logic [LW-1:0]    cur_q, cur_nx;
    logic [NCOND-1:0] stat [NLEV];
    logic [NLEV-1:0]  pend;
    logic [NLEV-1:0]  mask_q;
    logic [NLEV-1:0]  isr_q;
    logic [NLEV-1:0]  blk;
    logic [NLEV-1:0]  elig;
    logic [NLEV-1:0]  isr_set, isr_clr;
    logic             best_found, lo_found;
    logic [LW-1:0]    best_idx, lo_idx;
    logic [NCOND-1:0] rd_word;

    for (genvar g = 0; g < NLEV; g++) begin : g_lvl
        pic_level_status #(.NCOND(NCOND)) u_stat (
            .clk    (clk),
            .rst_n  (rst_n),
            .cond   (cond_i[g*NCOND +: NCOND]),
            .rd_hit (rd_en_i && (rd_lvl_i == LW'(g))),
            .status (stat[g]),
            .pending(pend[g])
        );
    end

    // a level is blocked by itself or any more urgent level in service
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < NLEV; i++) begin
            acc    = acc | isr_q[i];
            blk[i] = acc;
        end
    end

    assign elig = pend & ~mask_q & ~blk;

    pic_first_set #(.N(NLEV), .IW(LW)) u_best (
        .vec  (elig),
        .found(best_found),
        .idx  (best_idx)
    );

    pic_first_set #(.N(NLEV), .IW(LW)) u_isr_lo (
        .vec  (isr_q),
        .found(lo_found),
        .idx  (lo_idx)
    );

    // next-state logic
    always_comb begin
        state_nx = state_q;
        cur_nx   = cur_q;
        unique case (state_q)
            ST_IDLE: begin
                if (best_found) begin            // T_RAISE
                    state_nx = ST_REQ;
                    cur_nx   = best_idx;
                end
            end
            ST_REQ: begin
                if (ack_i) begin                 // T_ACCEPT
                    state_nx = ST_IDLE;
                end else if (!best_found || best_idx != cur_q) begin
                    state_nx = ST_IDLE;          // T_WITHDRAW
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_nx;
            cur_q   <= cur_nx;
        end
    end

    assign isr_set = (state_q == ST_REQ && ack_i) ? (NLEV'(1) << cur_q) : '0;
    assign isr_clr = (eos_i && lo_found) ? (NLEV'(1) << lo_idx) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q  <= '0;
            mask_q <= '0;
        end else begin
            isr_q <= (isr_q & ~isr_clr) | isr_set;
            if (mask_we_i) begin
                mask_q <= mask_wdata_i;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NLEV; i++) begin
            if (rd_lvl_i == LW'(i)) begin
                rd_word = stat[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_o <= '0;
        end else if (rd_en_i) begin
            rd_data_o <= rd_word;
        end
    end

    // outputs
    always_comb begin
        irq_o = (state_q == ST_REQ);
        lvl_o = cur_q;
        vec_o = VEC_BASE + AW'(cur_q);
    end
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
    parameter int NLEV = 24,
    parameter int LW   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq_o,
    input logic            ack_i,
    input logic            eos_i,
    input logic [LW-1:0]   lvl_o,
    input logic [NLEV-1:0] isr_q,
    input logic [NLEV-1:0] mask_q
);
    logic [NLEV-1:0] lowm;
    always_comb lowm = ((NLEV'(1) << lvl_o) << 1) - NLEV'(1);

    assert_lvl_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (int'(lvl_o) < NLEV));

    assert_not_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((isr_q & lowm) == '0));

    assert_ack_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i) |=> (!irq_o && ((isr_q & (NLEV'(1) << $past(lvl_o))) != '0)));

    assert_eos_retires_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eos_i && (isr_q != '0) && !(irq_o && ack_i)) |=>
            ($countones(isr_q) + 1 == $countones($past(isr_q))));

    assert_held_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && $past(irq_o) && $stable(lvl_o)) |->
            (($past(mask_q) & (NLEV'(1) << lvl_o)) == '0));
endmodule

bind prio_irq_ctrl pic_chk #(.NLEV(NLEV), .LW(LW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .irq_o (irq_o),
    .ack_i (ack_i),
    .eos_i (eos_i),
    .lvl_o (lvl_o),
    .isr_q (isr_q),
    .mask_q(mask_q)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    localparam int NL = 24;
    localparam int NC = 16;
    localparam logic [15:0] BASE = 16'h0008;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NL*NC-1:0] cond = '0;
    logic mask_we = 1'b0;
    logic [NL-1:0] mask_wd = '0;
    logic ack = 1'b0, eos = 1'b0, rd_en = 1'b0;
    logic [4:0] rd_lvl = '0;
    logic irq;
    logic [4:0] lvl;
    logic [15:0] vec, rd_data;

    int n_chk = 0, n_fail = 0;
    string tag = "R1";

    always #10 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cond_i(cond), .mask_we_i(mask_we),
        .mask_wdata_i(mask_wd), .ack_i(ack), .eos_i(eos), .rd_en_i(rd_en),
        .rd_lvl_i(rd_lvl), .irq_o(irq), .lvl_o(lvl), .vec_o(vec), .rd_data_o(rd_data)
    );

    // behavioural reference model
    logic [15:0] m_stat [NL];
    bit [NL-1:0] m_mask, m_isr;
    bit m_req;
    int m_lvl;
    logic [15:0] m_rd;
    logic [NL*NC-1:0] m_cq;

    always @(posedge clk) begin : model
        int best;
        bit bl;
        bit [NL-1:0] nisr;
        if (!rst_n) begin
            for (int l = 0; l < NL; l++) m_stat[l] = '0;
            m_mask = '0; m_isr = '0; m_req = 0; m_lvl = 0; m_rd = '0; m_cq = '0;
        end else begin
            best = -1; bl = 0;
            for (int l = 0; l < NL; l++) begin
                bl = bl | m_isr[l];
                if (best < 0 && m_stat[l] != 0 && !m_mask[l] && !bl) best = l;
            end
            nisr = m_isr;
            if (eos) begin
                for (int l = 0; l < NL; l++) if (m_isr[l]) begin nisr[l] = 0; break; end
            end
            if (m_req && ack) nisr[m_lvl] = 1;
            if (!m_req) begin
                if (best >= 0) begin m_req = 1; m_lvl = best; end
            end else if (ack || best != m_lvl) begin
                m_req = 0;
            end
            if (rd_en) begin
                if (rd_lvl < NL) begin m_rd = m_stat[rd_lvl]; m_stat[rd_lvl] = '0; end
                else m_rd = '0;
            end
            for (int l = 0; l < NL; l++)
                for (int b = 0; b < NC; b++)
                    if (cond[l*NC+b] && !m_cq[l*NC+b]) m_stat[l][b] = 1'b1;
            m_cq = cond;
            if (mask_we) m_mask = mask_wd;
            m_isr = nisr;
        end
    end

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic compare();
        check(irq == m_req, tag, irq, m_req);
        if (m_req) begin
            check(lvl == 5'(m_lvl), tag, lvl, m_lvl);
            check(vec == BASE + 16'(m_lvl), tag, vec, BASE + 16'(m_lvl));
        end
        check(rd_data == m_rd, tag, rd_data, m_rd);
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
    endtask

    task automatic rd(input int l);
        rd_en = 1; rd_lvl = 5'(l); tick(); rd_en = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        // R1: reset state
        tick();
        check(irq == 0 && lvl == 0 && rd_data == 0, "R1", irq, 0);
        rd(0); check(rd_data == 0, "R1", rd_data, 0);
        rd(23); check(rd_data == 0, "R1", rd_data, 0);

        // mask everything for the status tests
        mask_we = 1; mask_wd = '1; tick(); mask_we = 0;
        tag = "R2";
        cond[5*NC+3] = 1; cond[5*NC+0] = 1; tick();
        cond[5*NC+0] = 0; tick(); tick();
        rd(5); check(rd_data == 16'h0009, "R2", rd_data, 16'h0009);
        rd(5); check(rd_data == 16'h0000, "R2", rd_data, 0);

        tag = "R3";
        cond[7*NC+1] = 1; tick(); cond[7*NC+1] = 0;
        rd_en = 1; rd_lvl = 7; cond[7*NC+2] = 1; tick(); rd_en = 0;
        check(rd_data == 16'h0002, "R3", rd_data, 16'h0002);
        rd(7); check(rd_data == 16'h0004, "R3", rd_data, 16'h0004);
        rd(30); check(rd_data == 16'h0000, "R3", rd_data, 0);
        cond = '0; tick();

        tag = "R6";
        mask_we = 1; mask_wd = 24'h000010; tick(); mask_we = 0;
        cond[4*NC+0] = 1; tick(); cond = '0;
        repeat (3) tick();
        check(irq == 0, "R6", irq, 0);
        mask_we = 1; mask_wd = '0; tick(); mask_we = 0;
        tick();
        tag = "R4";
        check(irq == 1 && lvl == 4, "R6", lvl, 4);
        check(vec == 16'h000C, "R4", vec, 16'h000C);

        tag = "R8";
        ack = 1; tick(); ack = 0;
        check(irq == 0, "R8", irq, 0);
        tag = "R7";
        tick(); check(irq == 0, "R7", irq, 0);
        cond[6*NC+0] = 1; tick(); cond = '0; tick(); tick();
        check(irq == 0, "R7", irq, 0);
        cond[2*NC+5] = 1; tick(); cond = '0; tick();
        check(irq == 1 && lvl == 2, "R7", lvl, 2);

        tag = "R10";
        ack = 1; eos = 1; tick(); ack = 0; eos = 0;
        tick(); check(irq == 0, "R10", irq, 0);
        rd(2); check(rd_data == 16'h0020, "R3", rd_data, 16'h0020);
        eos = 1; tick(); eos = 0; tick();
        check(irq == 1 && lvl == 4, "R10", lvl, 4);

        tag = "R11";
        cond[1*NC+0] = 1; tick(); cond = '0; tick();
        check(irq == 0, "R11", irq, 0);
        tick(); check(irq == 1 && lvl == 1, "R11", lvl, 1);

        tag = "R9";
        ack = 1; tick(); ack = 0;
        rd(1); rd(4); rd(6);
        eos = 1; tick(); eos = 0; tick();
        check(irq == 0, "R9", irq, 0);
        eos = 1; tick(); eos = 0; tick();
        check(irq == 0, "R9", irq, 0);

        tag = "R5";
        cond[20*NC+1] = 1; cond[9*NC+7] = 1; tick(); cond = '0; tick();
        check(irq == 1 && lvl == 9, "R5", lvl, 9);
        check(vec == 16'h0011, "R5", vec, 16'h0011);

        // random traffic with collisions of all kinds
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(0, 3) == 0) cond[$urandom_range(0, NL*NC-1)] ^= 1'b1;
            ack = irq && ($urandom_range(0, 2) == 0);
            eos = ($urandom_range(0, 11) == 0);
            rd_en = ($urandom_range(0, 5) == 0);
            rd_lvl = 5'($urandom_range(0, 25));
            mask_we = ($urandom_range(0, 63) == 0);
            mask_wd = 24'($urandom) & 24'($urandom) & 24'($urandom);
            tick();
        end
        ack = 0; eos = 0; rd_en = 0; mask_we = 0;
        tick();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule